// File: doc/BRIEF.md
# I2C Target Register-File Port

This block lets an external bus master reach a small byte-wide register file over a two-wire serial bus. The block watches SCL and SDA through synchronizers and a majority filter in the system clock domain. It recognises start, repeated start and stop conditions and answers to one fixed 7-bit device address. It drives SDA only by pulling it low, so the pad is an open-drain output.

On its register side it has a write strobe and a read strobe, each with an address. In a write transaction the first byte after the address sets an internal pointer and each later byte is written at that pointer. In a read transaction bytes come out starting at the pointer. After every byte the pointer steps on by one and wraps at the end of the file. The pointer is kept between transactions, so a master can set it once with a short write and then read from there, or read again from where it stopped.

The register side has no back-pressure. The bus cannot be held off, so there is no ready signal. The register file must take every write strobe in the cycle it is raised, and it must present read data in the cycle after a read strobe.

Top module: `i2c_regfile_target`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits are 1101000, that is 0xD0 for a write and 0xD1 for a read. Any other address byte gets no acknowledge, and every byte after it up to the next start condition is ignored: no acknowledge and no strobe.
- R2: In a write transaction the byte after the address loads the pointer. Each further byte is acknowledged and raises one write strobe carrying the pointer as address and the byte as data. The pointer then increments, wrapping from 0x0F to 0x00.
- R3: A pointer byte above 0x0F is not acknowledged. Later bytes get no acknowledge and no write strobe, and the pointer keeps its previous value.
- R4: In a read transaction bytes are sent MSB first, starting at the pointer. The pointer increments after each byte and wraps from 0x0F to 0x00. A transaction may carry any number of bytes.
- R5: A read addressed directly after a start condition, with no pointer write before it, starts at the pointer left by the previous transaction. After reset the pointer is 0x00.
- R6: The SDA pull-low output changes only while SCL is low. An acknowledge is driven low for the whole of the ninth SCL pulse.
- R7: When the master does not acknowledge a read byte, the block raises no further read strobe and keeps SDA released until the next start or stop condition.
- R8: A start or repeated start seen in any state drops any partial byte and returns the block to address matching. A stop condition releases SDA and makes the block idle.
- R9: Each strobe lasts one cycle, and a write strobe and a read strobe are never high in the same cycle. Read data is taken from the register file in the cycle after the read strobe.
- R10: While reset is held and just after it is released, SDA is released and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | High to pull SDA low |
| wr_valid_o | output | 1 | Write strobe, one cycle |
| wr_addr_o | output | PTR_W | Register address for the write |
| wr_data_o | output | 8 | Byte to write |
| rd_valid_o | output | 1 | Read strobe, one cycle |
| rd_addr_o | output | PTR_W | Register address for the read |
| rd_data_i | input | 8 | Read data, valid the cycle after the read strobe |

## Verification
The bench uses the default parameters. A 4-bit pointer gives a 16-entry file, which puts the 0x0F to 0x00 wrap in both directions and the rejection of pointer 0x20 within a few bus bytes. It also uses a two-stage synchronizer and a three-tap filter. A quarter bit period of 16 system cycles leaves margin over the filter latency, so every read fetch finishes well before SCL next rises. Together these let one run cover pointer persistence across transactions, a master NACK followed by extra clocking, and a repeated start in the middle of a byte.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;
  localparam int LINES  = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_WDATA,
    ST_RDATA
  } tgt_state_e;
endpackage

// File: rtl/i2c_line_cond.sv
module i2c_line_cond #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_TAPS   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CNT_W = $clog2(FILT_TAPS + 1);
  localparam int HALF  = FILT_TAPS / 2;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_TAPS-1:0]   hist_q;
  logic [CNT_W-1:0]       votes;
  logic                   level_q;
  logic                   prev_q;

  always_comb begin
    votes = '0;
    for (int i = 0; i < FILT_TAPS; i++) begin
      votes = votes + CNT_W'(hist_q[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '1;
      hist_q  <= '1;
      level_q <= 1'b1;
      prev_q  <= 1'b1;
    end else begin
      sync_q  <= {sync_q[SYNC_STAGES-2:0], line_i};
      hist_q  <= {hist_q[FILT_TAPS-2:0], sync_q[SYNC_STAGES-1]};
      level_q <= (votes > CNT_W'(HALF));
      prev_q  <= level_q;
    end
  end

  assign level_o = level_q;
  assign rise_o  = level_q & ~prev_q;
  assign fall_o  = ~level_q & prev_q;
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
#(
  parameter int         PTR_W    = 4,
  parameter logic [6:0] DEV_ADDR = 7'h68
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_lvl,
  input  logic              start_det,
  input  logic              stop_det,
  output logic              sda_pull_o,
  output logic              wr_valid_o,
  output logic [PTR_W-1:0]  wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              rd_valid_o,
  output logic [PTR_W-1:0]  rd_addr_o,
  input  logic [BYTE_W-1:0] rd_data_i,
  output tgt_state_e        state_o
);
  localparam logic [3:0] LAST_BIT = 4'd8;
  localparam logic [3:0] ACK_BIT  = 4'd9;

  tgt_state_e        state_q, pend_q;
  logic [3:0]        bit_q;
  logic [BYTE_W-1:0] shreg_q;
  logic [BYTE_W-1:0] tx_q;
  logic              tx_en_q;
  logic              ack_q;
  logic              nack_q;
  logic              fetch_q;
  logic [PTR_W-1:0]  ptr_q;
  logic              ptr_ok;

  assign ptr_ok = (shreg_q[BYTE_W-1:PTR_W] == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      pend_q     <= ST_IDLE;
      bit_q      <= '0;
      shreg_q    <= '0;
      tx_q       <= '0;
      tx_en_q    <= 1'b0;
      ack_q      <= 1'b0;
      nack_q     <= 1'b0;
      fetch_q    <= 1'b0;
      ptr_q      <= '0;
      wr_valid_o <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
      rd_valid_o <= 1'b0;
      rd_addr_o  <= '0;
    end else begin
      wr_valid_o <= 1'b0;
      rd_valid_o <= 1'b0;
      fetch_q    <= rd_valid_o;

      if (fetch_q) begin
        tx_q <= rd_data_i;
        if (state_q == ST_RDATA && bit_q == '0) tx_en_q <= 1'b1;
      end

      if (start_det || stop_det) begin
        state_q <= start_det ? ST_ADDR : ST_IDLE;
        bit_q   <= '0;
        ack_q   <= 1'b0;
        tx_en_q <= 1'b0;
      end else if (state_q != ST_IDLE) begin
        if (scl_rise) begin
          if (bit_q < LAST_BIT) begin
            shreg_q <= {shreg_q[BYTE_W-2:0], sda_lvl};
            bit_q   <= bit_q + 4'd1;
          end else if (bit_q == LAST_BIT) begin
            nack_q <= sda_lvl;
            bit_q  <= ACK_BIT;
          end
        end

        if (scl_fall) begin
          if (bit_q == LAST_BIT) begin
            unique case (state_q)
              ST_ADDR: begin
                if (shreg_q[BYTE_W-1:1] == DEV_ADDR) begin
                  ack_q <= 1'b1;
                  if (shreg_q[0]) begin
                    pend_q     <= ST_RDATA;
                    rd_valid_o <= 1'b1;
                    rd_addr_o  <= ptr_q;
                    ptr_q      <= ptr_q + 1'b1;
                  end else begin
                    pend_q <= ST_PTR;
                  end
                end else begin
                  pend_q <= ST_IDLE;
                end
              end
              ST_PTR: begin
                if (ptr_ok) begin
                  ack_q  <= 1'b1;
                  ptr_q  <= shreg_q[PTR_W-1:0];
                  pend_q <= ST_WDATA;
                end else begin
                  pend_q <= ST_IDLE;
                end
              end
              ST_WDATA: begin
                ack_q      <= 1'b1;
                wr_valid_o <= 1'b1;
                wr_addr_o  <= ptr_q;
                wr_data_o  <= shreg_q;
                ptr_q      <= ptr_q + 1'b1;
                pend_q     <= ST_WDATA;
              end
              ST_RDATA: begin
                tx_en_q <= 1'b0;
                pend_q  <= ST_RDATA;
              end
              default: pend_q <= ST_IDLE;
            endcase
          end else if (bit_q == ACK_BIT) begin
            bit_q <= '0;
            ack_q <= 1'b0;
            if (state_q == ST_RDATA) begin
              if (nack_q) begin
                state_q <= ST_IDLE;
              end else begin
                state_q    <= ST_RDATA;
                rd_valid_o <= 1'b1;
                rd_addr_o  <= ptr_q;
                ptr_q      <= ptr_q + 1'b1;
              end
            end else begin
              state_q <= pend_q;
              if (state_q == ST_ADDR && pend_q == ST_RDATA) tx_en_q <= 1'b1;
            end
          end else if (bit_q != '0 && tx_en_q) begin
            tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign sda_pull_o = ack_q | (tx_en_q & ~tx_q[BYTE_W-1]);
  assign state_o    = state_q;
endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target
  import i2c_tgt_pkg::*;
#(
  parameter int         PTR_W       = 4,
  parameter logic [6:0] DEV_ADDR    = 7'h68,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_TAPS   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  output logic              wr_valid_o,
  output logic [PTR_W-1:0]  wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              rd_valid_o,
  output logic [PTR_W-1:0]  rd_addr_o,
  input  logic [BYTE_W-1:0] rd_data_i
);
  localparam int SCL_IDX = 0;
  localparam int SDA_IDX = 1;

  logic [LINES-1:0] raw, lvl, rise, fall;
  logic             scl_f, start_det, stop_det;
  tgt_state_e       state;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    i2c_line_cond #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_TAPS  (FILT_TAPS)
    ) u_cond (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (raw[g]),
      .level_o(lvl[g]),
      .rise_o (rise[g]),
      .fall_o (fall[g])
    );
  end

  assign scl_f     = lvl[SCL_IDX];
  assign start_det = fall[SDA_IDX] & scl_f;
  assign stop_det  = rise[SDA_IDX] & scl_f;

  i2c_tgt_engine #(
    .PTR_W   (PTR_W),
    .DEV_ADDR(DEV_ADDR)
  ) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_rise  (rise[SCL_IDX]),
    .scl_fall  (fall[SCL_IDX]),
    .sda_lvl   (lvl[SDA_IDX]),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_pull_o(sda_pull_o),
    .wr_valid_o(wr_valid_o),
    .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o),
    .rd_valid_o(rd_valid_o),
    .rd_addr_o (rd_addr_o),
    .rd_data_i (rd_data_i),
    .state_o   (state)
  );
endmodule

// File: rtl/i2c_tgt_checker.sv
module i2c_tgt_checker
  import i2c_tgt_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       sda_pull,
  input logic       wr_valid,
  input logic       rd_valid,
  input logic       scl_f,
  input logic       start_det,
  input logic       stop_det,
  input tgt_state_e state
);
  assert_pull_moves_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !scl_f);

  assert_strobe_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && rd_valid));

  assert_wr_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  assert_rd_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  assert_start_rearms_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> state == ST_ADDR);

  assert_stop_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull);
endmodule

bind i2c_regfile_target i2c_tgt_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sda_pull (sda_pull_o),
  .wr_valid (wr_valid_o),
  .rd_valid (rd_valid_o),
  .scl_f    (scl_f),
  .start_det(start_det),
  .stop_det (stop_det),
  .state    (state)
);

// File: tb/i2c_regfile_target_bench.sv
module i2c_regfile_target_bench;
  localparam int Q  = 16;
  localparam int NV = 5;
  // {pointer, first byte, second byte}
  localparam logic [23:0] VEC [NV] = '{
    24'h00_11_22, 24'h07_5A_A5, 24'h0E_C3_3C, 24'h0F_81_7E, 24'h03_FF_00
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_bus;
  logic sda_pull_o, wr_valid_o, rd_valid_o;
  logic [3:0] wr_addr_o, rd_addr_o;
  logic [7:0] wr_data_o, rd_data_i;

  int n_chk = 0;
  int n_bad = 0;
  int wr_cnt = 0;
  int rd_cnt = 0;
  int mon_r6 = 0;
  int mon_r9 = 0;
  logic prev_pull = 1'b0;
  logic [7:0] mem [16];

  always #10 clk = ~clk;

  assign sda_bus = sda_m & ~sda_pull_o;

  i2c_regfile_target u_i2c_regfile_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_pull_o(sda_pull_o),
    .wr_valid_o(wr_valid_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .rd_valid_o(rd_valid_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i)
  );

  // register file model with one-cycle read latency
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= 8'hA0 + 8'(i);
      rd_data_i <= 8'h00;
    end else begin
      if (wr_valid_o) begin
        mem[wr_addr_o] <= wr_data_o;
        wr_cnt <= wr_cnt + 1;
      end
      if (rd_valid_o) begin
        rd_data_i <= mem[rd_addr_o];
        rd_cnt <= rd_cnt + 1;
      end
    end
  end

  // monitors: R6 pull changes with SCL low, R9 exclusive strobes
  always @(negedge clk) begin
    if (rst_n) begin
      if (sda_pull_o != prev_pull && scl_m) mon_r6 <= mon_r6 + 1;
      if (wr_valid_o && rd_valid_o) mon_r9 <= mon_r9 + 1;
    end
    prev_pull <= sda_pull_o;
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic q;
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; q; scl_m = 1'b1; q; sda_m = 1'b0; q; scl_m = 1'b0; q;
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; q; scl_m = 1'b1; q; sda_m = 1'b1; q;
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; q; scl_m = 1'b1; q; q; scl_m = 1'b0; q;
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; q; scl_m = 1'b1; q; b = sda_bus; q; scl_m = 1'b0; q;
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic rd_byte(input logic give_ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    send_bit(~give_ack);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic a0, a1, a2, a3;
    logic [7:0] r0, r1, r2;
    int snap_w, snap_r;
    int zeros;

    // R10: reset state
    repeat (5) @(negedge clk);
    chk("R10 pull in reset", {15'd0, sda_pull_o}, 16'd0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R10 strobes after reset", {14'd0, wr_valid_o, rd_valid_o}, 16'd0);
    chk("R10 pull after reset", {15'd0, sda_pull_o}, 16'd0);

    // R5/R4: read from reset pointer 0
    bus_start; wr_byte(8'hD1, a0);
    rd_byte(1'b1, r0); rd_byte(1'b1, r1); rd_byte(1'b0, r2); bus_stop;
    chk("R1 read address ack", {15'd0, a0}, 16'd1);
    chk("R5 first byte from pointer 0", {8'd0, r0}, 16'h00A0);
    chk("R4 increment", {r1, r2}, 16'hA1A2);
    bus_start; wr_byte(8'hD1, a0); rd_byte(1'b0, r0); bus_stop;
    chk("R5 pointer kept across transactions", {8'd0, r0}, 16'h00A3);

    // table: write two bytes then read them back
    for (int k = 0; k < NV; k++) begin
      snap_w = wr_cnt;
      bus_start;
      wr_byte(8'hD0, a0); wr_byte(VEC[k][23:16], a1);
      wr_byte(VEC[k][15:8], a2); wr_byte(VEC[k][7:0], a3);
      bus_stop;
      chk("R2 write acks", {12'd0, a0, a1, a2, a3}, 16'h000F);
      chk("R2 write strobes", 16'(wr_cnt - snap_w), 16'd2);
      bus_start;
      wr_byte(8'hD0, a0); wr_byte(VEC[k][23:16], a1);
      bus_start;
      wr_byte(8'hD1, a2);
      rd_byte(1'b1, r0); rd_byte(1'b0, r1);
      bus_stop;
      chk("R1 repeated-start read ack", {13'd0, a0, a1, a2}, 16'h0007);
      chk("R4 readback with wrap", {r0, r1}, VEC[k][15:0]);
    end

    // R1: other address ignored
    snap_w = wr_cnt;
    bus_start; wr_byte(8'hA0, a0); wr_byte(8'h55, a1); bus_stop;
    chk("R1 foreign address not acked", {14'd0, a0, a1}, 16'd0);
    chk("R1 no write on foreign address", 16'(wr_cnt - snap_w), 16'd0);

    // R3: pointer out of range (pointer is 5 here)
    snap_w = wr_cnt;
    bus_start; wr_byte(8'hD0, a0); wr_byte(8'h20, a1); wr_byte(8'h99, a2); bus_stop;
    chk("R3 bad pointer nack", {13'd0, a0, a1, a2}, 16'h0004);
    chk("R3 no write after bad pointer", 16'(wr_cnt - snap_w), 16'd0);
    bus_start; wr_byte(8'hD1, a0); rd_byte(1'b0, r0); bus_stop;
    chk("R3 pointer unchanged", {8'd0, r0}, 16'h00A5);

    // R7: master NACK, then extra clocking
    bus_start; wr_byte(8'hD1, a0); rd_byte(1'b0, r0);
    snap_r = rd_cnt;
    zeros = 0;
    for (int i = 0; i < 9; i++) begin
      get_bit(a1);
      if (!a1) zeros++;
    end
    bus_stop;
    chk("R7 read byte", {8'd0, r0}, 16'h00A6);
    chk("R7 SDA released after nack", 16'(zeros), 16'd0);
    chk("R7 no fetch after nack", 16'(rd_cnt - snap_r), 16'd0);

    // R8: repeated start aborts a partial byte
    snap_w = wr_cnt;
    bus_start; wr_byte(8'hD0, a0); wr_byte(8'h0A, a1);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_start; wr_byte(8'hD1, a2); rd_byte(1'b0, r0); bus_stop;
    chk("R8 acks around restart", {13'd0, a0, a1, a2}, 16'h0007);
    chk("R8 partial byte not written", 16'(wr_cnt - snap_w), 16'd0);
    chk("R8 read after restart", {8'd0, r0}, 16'h00AA);

    chk("R6 pull changed while SCL high", 16'(mon_r6), 16'd0);
    chk("R9 both strobes in one cycle", 16'(mon_r9), 16'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule